// File: doc/BRIEF.md
# Power Switch Startup Sequencer

This controller decides when a protected power switch is allowed to close and supervises the startup window that follows. It reads the input-voltage comparators, an output-above-threshold flag, an output-charged flag, a flag telling that the current-program resistor reads as shorted, and two enable pins. One pin is active-low and one is active-high. Time runs from a 1 µs tick, and every interval is a parameter counted in ticks.

When turn-on conditions appear, the switch closes after a debounce interval. The debounce is skipped when the output is already above its own undervoltage threshold. Once closed, the switch first spends a window with a raised startup current-limit multiplier. It then continues to a longer charge timeout. If the output is charged when that timeout ends, a one-cycle done pulse lets a downstream block sample its mode pins. If the output is not charged, the switch opens and a fault latches. The fault clears only when the enable goes to off or when the input-undervoltage flag drops.

Top module: `pwr_start_seq`

## Requirements
- R1: The enable intent is on unless `hv_en_n`=1 and `lv_en`=0. Both pins pass through a two-flop synchronizer, so a pin change reaches `sw_on` on the third rising edge after it.
- R2: With `out_above_uv`=0, the switch closes (`sw_on`=1) only after DEB_TICKS ticks of continuous valid conditions. Valid means enable on, `in_uv_ok`=1, `in_ov`=0 and `iset_short`=0.
- R3: If the input becomes invalid during the debounce, the switch stays off. The next valid period counts the full debounce again from zero.
- R4: If `out_above_uv`=1 when turn-on conditions appear, the switch closes on the next edge with no debounce.
- R5: During the first STI_TICKS ticks after closing, `ilim_mult` equals MULT_CODE, where 00=1x, 01=1.5x and 10=2x. At every other time it is 00.
- R6: If `out_charged`=0 when STO_TICKS ticks have passed since closing, the switch opens and `start_fault` goes to 1.
- R7: If `out_charged`=1 at that expiry, `start_done` pulses high for exactly one cycle and the switch stays closed.
- R8: The fault latch clears on a falling edge of the synchronized enable intent or when `in_uv_ok`=0. An `in_ov` pulse alone leaves `start_fault` at 1.
- R9: While `iset_short`=1, the switch does not close.
- R10: An undervoltage, an overvoltage or enable-off opens the switch on the next edge. A later restart applies the debounce rule and the full startup window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle timebase tick |
| in_uv_ok | input | 1 | Input above undervoltage threshold |
| in_ov | input | 1 | Input above overvoltage threshold |
| out_above_uv | input | 1 | Output above its undervoltage threshold |
| out_charged | input | 1 | Output within drop threshold of input |
| iset_short | input | 1 | Current-program input reads shorted |
| hv_en_n | input | 1 | Active-low enable pin (asynchronous) |
| lv_en | input | 1 | Active-high enable pin (asynchronous) |
| sw_on | output | 1 | Switch-on request |
| ilim_mult | output | 2 | Startup current-limit multiplier code |
| start_done | output | 1 | One-cycle pulse on a successful startup |
| start_fault | output | 1 | Latched startup timeout fault |

## Verification
Changes on the comparator and program flags act on the next rising edge. Enable-pin changes take effect on the third edge, and each timed interval ends on the edge that carries its last tick. The bench keeps a cycle-stepped reference that advances only after each rising edge. It compares every output against that reference at the following falling edge, so each result is checked exactly in the cycle it is due. Directed sequences add hand-computed checks at points well clear of any interval boundary.

// File: rtl/pss_pkg.sv
// Shared types for the power-switch startup sequencer.
// Assumes: consumers import the package; no storage lives here.
package pss_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DEB   = 3'd1,
        PH_RAMP  = 3'd2,
        PH_ON    = 3'd3,
        PH_LATCH = 3'd4
    } phase_t;

    localparam logic [1:0] MULT_1X   = 2'b00;
    localparam logic [1:0] MULT_1P5X = 2'b01;
    localparam logic [1:0] MULT_2X   = 2'b10;
endpackage

// File: rtl/pss_en_sync.sv
// Synchronizes the two enable pins and forms the effective enable intent.
// Assumes: pins are asynchronous to clk; reset state is "off" (active-low pin high).
module pss_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hv_en_n,
    input  logic lv_en,
    output logic en_on,
    output logic en_fall
);
    logic [STAGES-1:0] hv_q;
    logic [STAGES-1:0] lv_q;
    logic              en_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift each pin one synchronizer stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hv_q[g] <= 1'b1;
                    lv_q[g] <= 1'b0;
                end else if (g == 0) begin
                    hv_q[g] <= hv_en_n;
                    lv_q[g] <= lv_en;
                end else begin
                    hv_q[g] <= hv_q[(g == 0) ? 0 : g-1];
                    lv_q[g] <= lv_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    // Off only when the active-low pin is high and the active-high pin is low.
    always_comb en_on = ~hv_q[STAGES-1] | lv_q[STAGES-1];

    // Remember last intent for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= en_on;
    end

    always_comb en_fall = en_prev & ~en_on;

    // R8
    en_fall_onecyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> !en_fall);
endmodule

// File: rtl/pss_tick_cnt.sv
// Saturating tick counter, cleared synchronously on phase changes.
// Assumes: tick is a single-cycle strobe; MAX fits the derived width.
module pss_tick_cnt #(
    parameter int MAX = 1200000,
    localparam int CW = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] cnt
);
    // Count ticks, holding at MAX.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                  cnt <= '0;
        else if (tick && cnt != CW'(MAX))   cnt <= cnt + 1'b1;
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX));
endmodule

// File: rtl/pwr_start_seq.sv
// Startup sequencer for a protected power switch: debounce, multiplier
// window, charge timeout with latch-off, and success pulse.
// Assumes: comparator and program flags are already synchronous to clk;
// DEB_TICKS and STI_TICKS do not exceed STO_TICKS; all tick counts >= 1.
module pwr_start_seq
    import pss_pkg::*;
#(
    parameter int         DEB_TICKS   = 1200,
    parameter int         STI_TICKS   = 24000,
    parameter int         STO_TICKS   = 1200000,
    parameter logic [1:0] MULT_CODE   = MULT_1X,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       in_uv_ok,
    input  logic       in_ov,
    input  logic       out_above_uv,
    input  logic       out_charged,
    input  logic       iset_short,
    input  logic       hv_en_n,
    input  logic       lv_en,
    output logic       sw_on,
    output logic [1:0] ilim_mult,
    output logic       start_done,
    output logic       start_fault
);
    localparam int CW = $clog2(STO_TICKS + 1);

    phase_t        ph, ph_nx;
    logic          en_on, en_fall;
    logic [CW-1:0] cnt;
    logic          vin_ok, go, deb_end, sto_end;

    pss_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .hv_en_n(hv_en_n), .lv_en(lv_en),
        .en_on(en_on), .en_fall(en_fall)
    );

    pss_tick_cnt #(.MAX(STO_TICKS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(ph != ph_nx), .tick(tick_us), .cnt(cnt)
    );

    // Qualify turn-on conditions and interval ends.
    always_comb begin
        vin_ok  = in_uv_ok & ~in_ov;
        go      = en_on & vin_ok;
        deb_end = tick_us && (cnt == CW'(DEB_TICKS - 1));
        sto_end = tick_us && (cnt == CW'(STO_TICKS - 1));
    end

    // Next-phase decision.
    always_comb begin
        ph_nx = ph;
        unique case (ph)
            PH_IDLE:  if (go && !iset_short) ph_nx = out_above_uv ? PH_RAMP : PH_DEB;
            PH_DEB:   if (!go || iset_short) ph_nx = PH_IDLE;
                      else if (deb_end)      ph_nx = PH_RAMP;
            PH_RAMP:  if (!go)               ph_nx = PH_IDLE;
                      else if (sto_end)      ph_nx = out_charged ? PH_ON : PH_LATCH;
            PH_ON:    if (!go)               ph_nx = PH_IDLE;
            PH_LATCH: if (en_fall || !in_uv_ok) ph_nx = PH_IDLE;
            default:  ph_nx = PH_IDLE;
        endcase
    end

    // Phase register and success pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph         <= PH_IDLE;
            start_done <= 1'b0;
        end else begin
            ph         <= ph_nx;
            start_done <= (ph == PH_RAMP) && (ph_nx == PH_ON);
        end
    end

    // Drive the switch, multiplier and fault outputs from the phase.
    always_comb begin
        sw_on       = (ph == PH_RAMP) || (ph == PH_ON);
        start_fault = (ph == PH_LATCH);
        ilim_mult   = ((ph == PH_RAMP) && (cnt < CW'(STI_TICKS))) ? MULT_CODE : MULT_1X;
    end

    // R9
    iset_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_on) |-> !$past(iset_short));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |-> sw_on && $past(out_charged));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |=> !start_done);
    // R10
    vin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vin_ok && !start_fault |=> !sw_on);
    // R6
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_fault) |-> !$past(out_charged) && !sw_on);
    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_fault && in_uv_ok && !en_fall |=> start_fault);
endmodule

// File: tb/sim_pwr_start_seq.sv
module sim_pwr_start_seq;
    localparam int DEB = 4;
    localparam int STI = 6;
    localparam int STO = 20;
    localparam logic [1:0] MC = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b0, in_uv_ok = 1'b0, in_ov = 1'b0, out_above_uv = 1'b0;
    logic out_charged = 1'b0, iset_short = 1'b0, hv_en_n = 1'b1, lv_en = 1'b0;
    logic sw_on, start_done, start_fault;
    logic [1:0] ilim_mult;

    int checks = 0, fails = 0, cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pwr_start_seq #(.DEB_TICKS(DEB), .STI_TICKS(STI), .STO_TICKS(STO), .MULT_CODE(MC)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .in_uv_ok(in_uv_ok), .in_ov(in_ov),
        .out_above_uv(out_above_uv), .out_charged(out_charged), .iset_short(iset_short),
        .hv_en_n(hv_en_n), .lv_en(lv_en), .sw_on(sw_on), .ilim_mult(ilim_mult),
        .start_done(start_done), .start_fault(start_fault));

    // Reference model state: 0 idle,1 debounce,2 ramp,3 on,4 latched
    int m_ph = 0, m_cnt = 0;
    logic [1:0] m_hv = 2'b11, m_lv = 2'b00;
    logic m_prev = 0, m_done = 0;

    function automatic bit en_intent(input logic hvn, input logic lv);
        return !(hvn && !lv);   // R1 truth rule
    endfunction

    task automatic model_step();
        bit en, fall, go;
        int nx;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_hv = 2'b11; m_lv = 2'b00; m_prev = 0; m_done = 0;
            return;
        end
        en   = en_intent(m_hv[1], m_lv[1]);
        fall = m_prev && !en;
        go   = en && in_uv_ok && !in_ov;
        nx   = m_ph;
        case (m_ph)
            0: if (go && !iset_short) nx = out_above_uv ? 2 : 1;
            1: if (!go || iset_short) nx = 0; else if (tick_us && m_cnt == DEB-1) nx = 2;
            2: if (!go) nx = 0; else if (tick_us && m_cnt == STO-1) nx = out_charged ? 3 : 4;
            3: if (!go) nx = 0;
            4: if (fall || !in_uv_ok) nx = 0;
            default: nx = 0;
        endcase
        m_done = (m_ph == 2) && (nx == 3);
        if (nx != m_ph) m_cnt = 0; else if (tick_us && m_cnt < STO) m_cnt++;
        m_ph   = nx;
        m_prev = en;
        m_hv   = {m_hv[0], hv_en_n};
        m_lv   = {m_lv[0], lv_en};
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // One clock: model advances after the edge, outputs compared at the falling edge.
    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            cycles++;
            if (rst_n) begin
                chk(sw_on == (m_ph == 2 || m_ph == 3), "R2 sw_on", sw_on, (m_ph == 2 || m_ph == 3));
                chk(ilim_mult == ((m_ph == 2 && m_cnt < STI) ? MC : 2'b00), "R5 ilim_mult",
                    ilim_mult, (m_ph == 2 && m_cnt < STI) ? MC : 0);
                chk(start_done == m_done, "R7 start_done", start_done, m_done);
                chk(start_fault == (m_ph == 4), "R6 start_fault", start_fault, (m_ph == 4));
            end
            tick_us = ~tick_us;
        end
    endtask

    task automatic all_off();
        hv_en_n = 1; lv_en = 0; in_uv_ok = 1; in_ov = 0; iset_short = 0;
        cyc(6);
    endtask

    initial begin
        int dcount;
        bit seen;
        void'($urandom(32'h5EED_1234));
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        chk(sw_on == 0 && start_fault == 0 && start_done == 0 && ilim_mult == 0,
            "R1 reset state", sw_on, 0);

        // R1: only hv_en_n=1 with lv_en=0 is off
        in_uv_ok = 1; out_above_uv = 1; out_charged = 1;
        cyc(10);
        chk(sw_on == 0, "R1 off combination", sw_on, 0);
        hv_en_n = 0; cyc(4);
        chk(sw_on == 1, "R1 hv low enables, R4 no debounce", sw_on, 1);
        lv_en = 1; hv_en_n = 1; cyc(4);
        chk(sw_on == 1, "R1 lv high enables", sw_on, 1);
        lv_en = 0; cyc(4);
        chk(sw_on == 0, "R1 off after both inactive", sw_on, 0);

        // R2: debounce when output below threshold
        out_above_uv = 0; lv_en = 1; cyc(5);
        chk(sw_on == 0, "R2 still in debounce", sw_on, 0);
        cyc(12);
        chk(sw_on == 1, "R2 closed after debounce", sw_on, 1);
        chk(ilim_mult == MC, "R5 multiplier in window", ilim_mult, MC);
        cyc(16);
        chk(ilim_mult == 2'b00, "R5 multiplier back to 1x", ilim_mult, 0);
        all_off();

        // R3: debounce aborted by undervoltage and restarted
        lv_en = 1; cyc(6);
        in_uv_ok = 0; cyc(1);
        in_uv_ok = 1; cyc(6);
        chk(sw_on == 0, "R3 debounce restarted", sw_on, 0);
        cyc(6);
        chk(sw_on == 1, "R3 closes after full debounce", sw_on, 1);
        // R10: overvoltage opens next edge, restart uses debounce again
        in_ov = 1; cyc(1);
        chk(sw_on == 0, "R10 opened by overvoltage", sw_on, 0);
        in_ov = 0; cyc(3);
        chk(sw_on == 0, "R10 restart debounced", sw_on, 0);
        all_off();

        // R7: successful startup, one pulse
        out_charged = 1; lv_en = 1; dcount = 0;
        for (int i = 0; i < 80; i++) begin
            cyc(1);
            if (start_done) dcount++;
        end
        chk(dcount == 1, "R7 single done pulse", dcount, 1);
        chk(sw_on == 1, "R7 stays on", sw_on, 1);
        all_off();

        // R6 / R8: timeout latch, ov ignored, cleared by enable off
        out_charged = 0; lv_en = 1; cyc(70);
        chk(start_fault == 1 && sw_on == 0, "R6 latched off", start_fault, 1);
        in_ov = 1; cyc(5); in_ov = 0; cyc(5);
        chk(start_fault == 1, "R8 ov pulse ignored", start_fault, 1);
        lv_en = 0; cyc(5);
        chk(start_fault == 0, "R8 cleared by enable off", start_fault, 0);
        lv_en = 1; cyc(70);
        chk(start_fault == 1, "R6 latched again", start_fault, 1);
        in_uv_ok = 0; cyc(2);
        chk(start_fault == 0, "R8 cleared by input cycle", start_fault, 0);
        all_off();

        // R9: program short blocks turn-on
        iset_short = 1; out_charged = 1; lv_en = 1; seen = 0;
        for (int i = 0; i < 60; i++) begin
            cyc(1);
            if (sw_on) seen = 1;
        end
        chk(seen == 0, "R9 short blocks switch", seen, 0);
        all_off();

        // Random phase: rare input changes so intervals can complete.
        for (int i = 0; i < 30000; i++) begin
            if ($urandom_range(0, 59) == 0) in_uv_ok     = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 79) == 0) in_ov        = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 39) == 0) out_above_uv = $urandom_range(0, 1);
            if ($urandom_range(0, 29) == 0) out_charged  = $urandom_range(0, 1);
            if ($urandom_range(0, 99) == 0) iset_short   = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 69) == 0) hv_en_n      = $urandom_range(0, 1);
            if ($urandom_range(0, 69) == 0) lv_en        = $urandom_range(0, 1);
            cyc(1);
        end

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule